// File: doc/BRIEF.md
# Transmit Descriptor Chain DMA Engine

This block feeds one serial transmit channel from host memory by following a linked list of transmit descriptors. Each descriptor takes three consecutive 32-bit words: a control word, the byte address of the next descriptor, and the byte address of the data buffer. The engine fetches a descriptor, moves the buffer contents into a transmit FIFO with per-byte enables, marks the final word of a frame, and raises interrupt pulses when a descriptor finishes. It then branches to the next descriptor.

The chain is terminated in one of two ways, selected at run time. In hold mode, a set hold bit parks the engine. A poll pulse makes it re-read the parked descriptor's control word and next pointer, and it continues only if hold has been cleared. In last-address mode, the hold bit is ignored and the engine parks after the descriptor whose address equals a last-address input. A poll then resumes the chain only if that input has been moved.

Memory reads go through a simple word-addressed read master that carries a burst length. Buffer reads are split into bursts of at most `MAX_BURST` words, and a burst is held back until the FIFO reports enough free words to take it.

Top module: `txdesc_dma`

## Requirements
- R1: A poll pulse while idle starts the chain: the first read request is at the word address of `desc_base_i`, with length 3. The three returned words are taken as control word, next-descriptor byte address, and buffer byte address, in that order.
- R2: The control word layout is: frame-end flag at bit 31, hold flag at bit 30, host interrupt flag at bit 29, and byte count in bits 12:0.
- R3: The buffer spans n = (offset + count + 3) >> 2 words, where offset is bits 1:0 of the buffer address. Those words are read from word address buffer[31:2] upward, each is written once to the FIFO, and a descriptor with n = 0 reads and writes no data.
- R4: The buffer is read in bursts of min(remaining, 15) words, issued in ascending address order.
- R5: A buffer burst request stays low while `fifo_space_i` is below its length. A burst whose length equals the free space is allowed.
- R6: FIFO data equals the memory word unchanged. `fifo_be_o` bit i enables byte lane i (bits 8i+7:8i). On the first word, lanes from offset up to 3 are set. On the last word, lanes 0 up to (offset + count - 1) mod 4 are set. All other words have 4'b1111; a one-word buffer gets both masks ANDed.
- R7: `fifo_fe_o` is set on the last data word of a descriptor exactly when its frame-end flag is 1, and is clear on all other words.
- R8: A descriptor with frame-end = 1 produces a one-cycle `irq_fi_o` pulse after its last FIFO write. Descriptors with frame-end = 0 produce none.
- R9: A descriptor with host-interrupt = 1 produces a one-cycle `irq_hi_o` pulse after its whole buffer is in the FIFO.
- R10: In hold mode (`lda_mode_i` = 0), a descriptor with hold = 1 parks the engine with no further reads. A poll re-reads that descriptor's first two words (length-2 request at its address). If hold is still set, the engine parks again; otherwise it fetches the descriptor at the re-read next pointer, without moving the parked buffer again.
- R11: In last-address mode (`lda_mode_i` = 1), hold is ignored and the engine parks after the descriptor whose address equals `last_addr_i`. A poll with `last_addr_i` unchanged does nothing; with it changed, the chain continues at the stored next pointer.
- R12: When a descriptor completes and the chain does not stop, the engine fetches the descriptor at its next pointer without needing a poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_i | input | 1 | Transmit poll pulse |
| desc_base_i | input | ADDR_W | Byte address of the first descriptor |
| lda_mode_i | input | 1 | 1 selects last-address termination, 0 selects hold-bit termination |
| last_addr_i | input | ADDR_W | Byte address of the last descriptor in last-address mode |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W-2 | Word address of the read |
| rd_len_o | output | LEN_W | Read length in words |
| rd_gnt_i | input | 1 | Request accepted |
| rd_vld_i | input | 1 | Read data valid |
| rd_data_i | input | 32 | Read data word |
| fifo_space_i | input | SPACE_W | Free FIFO words |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 32 | FIFO write data |
| fifo_be_o | output | 4 | Valid byte lanes of the written word |
| fifo_fe_o | output | 1 | Frame-end marker on the written word |
| irq_fi_o | output | 1 | Frame-indication interrupt pulse |
| irq_hi_o | output | 1 | Host-initiated interrupt pulse |

## Verification
The descriptor chain is driven with buffers at several byte offsets and lengths:
- An unaligned partial buffer separates the first-word and last-word lane masks.
- A one-byte buffer at offset 3 shows that both masks combine on a single word.
- A zero-length descriptor shows that no data moves while its interrupts still fire.
- A 160-byte buffer forces a split into 15, 15 and 10 word bursts.

A small reported FIFO space checks that requests are withheld until the space equals the burst length. In hold mode, polls are sent first with the hold bit still set and then with it cleared, which separates parking again from branching on the re-read pointer. In last-address mode, a held descriptor passes through. Polls with an unchanged and then a moved last address show that only a moved address resumes the chain.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;

   localparam int unsigned WORD_W  = 32;
   localparam int unsigned CW_FE   = 31;
   localparam int unsigned CW_HOLD = 30;
   localparam int unsigned CW_HI   = 29;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DREQ,
      ST_DRD,
      ST_SETUP,
      ST_BREQ,
      ST_BRD,
      ST_DONE,
      ST_PARK,
      ST_PREQ,
      ST_PRD,
      ST_EVAL
   } txd_state_e;

endpackage

// File: rtl/txd_span_calc.sv
module txd_span_calc #(
   parameter int unsigned NO_W = 13
) (
   input  logic [NO_W-1:0] byte_cnt_i,
   input  logic [1:0]      offset_i,
   output logic [NO_W-1:0] n_words_o,
   output logic [3:0]      first_be_o,
   output logic [3:0]      last_be_o
);

   localparam int unsigned SUM_W = NO_W + 2;

   logic [SUM_W-1:0] sum;
   logic [1:0]       last_lane;

   assign sum       = SUM_W'(offset_i) + SUM_W'(byte_cnt_i) + SUM_W'(3);
   assign n_words_o = sum[SUM_W-1:2];
   assign last_lane = sum[1:0];

   for (genvar g = 0; g < 4; g++) begin : g_lane
      assign first_be_o[g] = (2'(g) >= offset_i);
      assign last_be_o[g]  = (2'(g) <= last_lane);
   end

endmodule

// File: rtl/txd_burst_plan.sv
module txd_burst_plan #(
   parameter int unsigned CNT_W     = 13,
   parameter int unsigned MAX_BURST = 15,
   parameter int unsigned SPACE_W   = 6,
   parameter int unsigned LEN_W     = 4
) (
   input  logic [CNT_W-1:0]   remaining_i,
   input  logic [SPACE_W-1:0] space_i,
   output logic [LEN_W-1:0]   len_o,
   output logic               fits_o
);

   logic [SPACE_W-1:0] len_ext;

   if (CNT_W > LEN_W) begin : g_clip
      assign len_o = (remaining_i > CNT_W'(MAX_BURST)) ? LEN_W'(MAX_BURST)
                                                       : LEN_W'(remaining_i);
   end else begin : g_pass
      assign len_o = (LEN_W'(remaining_i) > LEN_W'(MAX_BURST)) ? LEN_W'(MAX_BURST)
                                                                : LEN_W'(remaining_i);
   end

   assign len_ext = SPACE_W'(len_o);
   assign fits_o  = (space_i >= len_ext);

endmodule

// File: rtl/txd_fifo_stage.sv
module txd_fifo_stage (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        beat_i,
   input  logic [31:0] data_i,
   input  logic        first_i,
   input  logic        last_i,
   input  logic [3:0]  first_be_i,
   input  logic [3:0]  last_be_i,
   input  logic        fe_flag_i,
   output logic        wr_o,
   output logic [31:0] data_o,
   output logic [3:0]  be_o,
   output logic        fe_o
);

   logic [3:0] be_mask;

   assign be_mask = (first_i ? first_be_i : 4'hF) & (last_i ? last_be_i : 4'hF);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_o   <= 1'b0;
         data_o <= '0;
         be_o   <= '0;
         fe_o   <= 1'b0;
      end else begin
         wr_o <= beat_i;
         fe_o <= beat_i & last_i & fe_flag_i;
         if (beat_i) begin
            data_o <= data_i;
            be_o   <= be_mask;
         end
      end
   end

   a_r7_fe_on_write : assert property (@(posedge clk) disable iff (!rst_n)
      fe_o |-> wr_o);

   a_r6_lanes_present : assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |-> (be_o != 4'h0));

endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
   import txdesc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned NO_W      = 13,
   parameter int unsigned MAX_BURST = 15,
   parameter int unsigned SPACE_W   = 6,
   localparam int unsigned WA_W     = ADDR_W - 2,
   localparam int unsigned LEN_W    = $clog2(MAX_BURST + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               poll_i,
   input  logic [ADDR_W-1:0]  desc_base_i,
   input  logic               lda_mode_i,
   input  logic [ADDR_W-1:0]  last_addr_i,
   output logic               rd_req_o,
   output logic [WA_W-1:0]    rd_addr_o,
   output logic [LEN_W-1:0]   rd_len_o,
   input  logic               rd_gnt_i,
   input  logic               rd_vld_i,
   input  logic [31:0]        rd_data_i,
   input  logic [SPACE_W-1:0] fifo_space_i,
   output logic               fifo_wr_o,
   output logic [31:0]        fifo_data_o,
   output logic [3:0]         fifo_be_o,
   output logic               fifo_fe_o,
   output logic               irq_fi_o,
   output logic               irq_hi_o
);

   localparam int unsigned CNT_W = NO_W;

   if (MAX_BURST < 3 || MAX_BURST > 15) begin : g_bad_burst
      $error("MAX_BURST must lie in 3..15");
   end
   if (SPACE_W < LEN_W) begin : g_bad_space
      $error("SPACE_W too narrow for a full burst");
   end
   if (ADDR_W > WORD_W || ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must lie in 4..32");
   end
   if (NO_W > 29 || NO_W < 2) begin : g_bad_no
      $error("NO_W must lie in 2..29");
   end

   txd_state_e         state;
   logic [ADDR_W-1:0]  cur_addr;
   logic [ADDR_W-1:0]  nxt_addr;
   logic [ADDR_W-1:0]  buf_addr;
   logic               fe_r;
   logic               hold_r;
   logic               hi_r;
   logic [NO_W-1:0]    cnt_r;
   logic [1:0]         widx;
   logic [CNT_W-1:0]   rem;
   logic [WA_W-1:0]    waddr;
   logic [LEN_W-1:0]   blen;
   logic [LEN_W-1:0]   bcnt;
   logic               first_r;

   logic [NO_W-1:0]    n_words;
   logic [3:0]         first_be;
   logic [3:0]         last_be;
   logic [LEN_W-1:0]   plan_len;
   logic               plan_fits;
   logic               beat;
   logic               stop_here;

   txd_span_calc #(.NO_W(NO_W)) u_span (
      .byte_cnt_i (cnt_r),
      .offset_i   (buf_addr[1:0]),
      .n_words_o  (n_words),
      .first_be_o (first_be),
      .last_be_o  (last_be)
   );

   txd_burst_plan #(
      .CNT_W     (CNT_W),
      .MAX_BURST (MAX_BURST),
      .SPACE_W   (SPACE_W),
      .LEN_W     (LEN_W)
   ) u_plan (
      .remaining_i (rem),
      .space_i     (fifo_space_i),
      .len_o       (plan_len),
      .fits_o      (plan_fits)
   );

   assign beat = (state == ST_BRD) && rd_vld_i;

   txd_fifo_stage u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat_i     (beat),
      .data_i     (rd_data_i),
      .first_i    (first_r),
      .last_i     (rem == CNT_W'(1)),
      .first_be_i (first_be),
      .last_be_i  (last_be),
      .fe_flag_i  (fe_r),
      .wr_o       (fifo_wr_o),
      .data_o     (fifo_data_o),
      .be_o       (fifo_be_o),
      .fe_o       (fifo_fe_o)
   );

   // read master request
   always_comb begin
      rd_req_o  = 1'b0;
      rd_addr_o = cur_addr[ADDR_W-1:2];
      rd_len_o  = LEN_W'(3);
      unique case (state)
         ST_DREQ: rd_req_o = 1'b1;
         ST_PREQ: begin
            rd_req_o = 1'b1;
            rd_len_o = LEN_W'(2);
         end
         ST_BREQ: begin
            rd_req_o  = plan_fits;
            rd_addr_o = waddr;
            rd_len_o  = plan_len;
         end
         default: ;
      endcase
   end

   assign stop_here = lda_mode_i ? (cur_addr == last_addr_i) : hold_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur_addr <= '0;
         nxt_addr <= '0;
         buf_addr <= '0;
         fe_r     <= 1'b0;
         hold_r   <= 1'b0;
         hi_r     <= 1'b0;
         cnt_r    <= '0;
         widx     <= '0;
         rem      <= '0;
         waddr    <= '0;
         blen     <= '0;
         bcnt     <= '0;
         first_r  <= 1'b0;
         irq_fi_o <= 1'b0;
         irq_hi_o <= 1'b0;
      end else begin
         irq_fi_o <= 1'b0;
         irq_hi_o <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (poll_i) begin
                  cur_addr <= desc_base_i;
                  state    <= ST_DREQ;
               end
            end
            ST_DREQ: begin
               if (rd_gnt_i) begin
                  widx  <= '0;
                  state <= ST_DRD;
               end
            end
            ST_DRD: begin
               if (rd_vld_i) begin
                  widx <= widx + 2'd1;
                  unique case (widx)
                     2'd0: begin
                        fe_r   <= rd_data_i[CW_FE];
                        hold_r <= rd_data_i[CW_HOLD];
                        hi_r   <= rd_data_i[CW_HI];
                        cnt_r  <= rd_data_i[NO_W-1:0];
                     end
                     2'd1: nxt_addr <= rd_data_i[ADDR_W-1:0];
                     default: begin
                        buf_addr <= rd_data_i[ADDR_W-1:0];
                        state    <= ST_SETUP;
                     end
                  endcase
               end
            end
            ST_SETUP: begin
               rem     <= n_words;
               waddr   <= buf_addr[ADDR_W-1:2];
               first_r <= 1'b1;
               state   <= (n_words == '0) ? ST_DONE : ST_BREQ;
            end
            ST_BREQ: begin
               if (rd_req_o && rd_gnt_i) begin
                  blen  <= plan_len;
                  bcnt  <= '0;
                  state <= ST_BRD;
               end
            end
            ST_BRD: begin
               if (rd_vld_i) begin
                  rem     <= rem - CNT_W'(1);
                  waddr   <= waddr + WA_W'(1);
                  first_r <= 1'b0;
                  bcnt    <= bcnt + LEN_W'(1);
                  if (bcnt == blen - LEN_W'(1)) begin
                     state <= (rem == CNT_W'(1)) ? ST_DONE : ST_BREQ;
                  end
               end
            end
            ST_DONE: begin
               irq_fi_o <= fe_r;
               irq_hi_o <= hi_r;
               if (stop_here) begin
                  state <= ST_PARK;
               end else begin
                  cur_addr <= nxt_addr;
                  state    <= ST_DREQ;
               end
            end
            ST_PARK: begin
               if (poll_i) begin
                  if (!lda_mode_i) begin
                     state <= ST_PREQ;
                  end else if (last_addr_i != cur_addr) begin
                     cur_addr <= nxt_addr;
                     state    <= ST_DREQ;
                  end
               end
            end
            ST_PREQ: begin
               if (rd_gnt_i) begin
                  widx  <= '0;
                  state <= ST_PRD;
               end
            end
            ST_PRD: begin
               if (rd_vld_i) begin
                  widx <= widx + 2'd1;
                  if (widx == 2'd0) begin
                     hold_r <= rd_data_i[CW_HOLD];
                  end else begin
                     nxt_addr <= rd_data_i[ADDR_W-1:0];
                     state    <= ST_EVAL;
                  end
               end
            end
            ST_EVAL: begin
               if (hold_r) begin
                  state <= ST_PARK;
               end else begin
                  cur_addr <= nxt_addr;
                  state    <= ST_DREQ;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   a_r4_burst_cap : assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> (rd_len_o >= LEN_W'(1) && rd_len_o <= LEN_W'(MAX_BURST)));

   a_r5_space_ok : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && state == ST_BREQ) |-> (fifo_space_i >= SPACE_W'(rd_len_o)));

   a_r8_fi_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      irq_fi_o |=> !irq_fi_o);

   a_r9_hi_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      irq_hi_o |=> !irq_hi_o);

   a_r1_req_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_gnt_i && state != ST_BREQ) |=> (rd_req_o && $stable(rd_addr_o)));

endmodule

// File: tb/tb_txdesc_dma.sv
`timescale 1ns/1ps
module tb_txdesc_dma;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        poll = 1'b0;
   logic [31:0] desc_base = '0;
   logic        lda_mode = 1'b0;
   logic [31:0] last_addr = '0;
   logic        rd_req;
   logic [29:0] rd_addr;
   logic [3:0]  rd_len;
   logic        rd_gnt = 1'b0;
   logic        rd_vld = 1'b0;
   logic [31:0] rd_data = '0;
   logic [5:0]  fifo_space = 6'd31;
   logic        fifo_wr;
   logic [31:0] fifo_data;
   logic [3:0]  fifo_be;
   logic        fifo_fe;
   logic        irq_fi;
   logic        irq_hi;

   always #4 clk = ~clk;

   txdesc_dma dut (
      .clk(clk), .rst_n(rst_n), .poll_i(poll), .desc_base_i(desc_base),
      .lda_mode_i(lda_mode), .last_addr_i(last_addr),
      .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_len_o(rd_len),
      .rd_gnt_i(rd_gnt), .rd_vld_i(rd_vld), .rd_data_i(rd_data),
      .fifo_space_i(fifo_space), .fifo_wr_o(fifo_wr), .fifo_data_o(fifo_data),
      .fifo_be_o(fifo_be), .fifo_fe_o(fifo_fe), .irq_fi_o(irq_fi), .irq_hi_o(irq_hi)
   );

   logic [31:0] mem [256];
   int          nchk = 0;
   int          nfail = 0;
   bit          done = 0;

   int          nreq, nwr, nfi, nhi, fi_wr, hi_wr;
   logic [29:0] req_addr [16];
   int          req_len  [16];
   logic [31:0] f_data   [64];
   logic [3:0]  f_be     [64];
   logic        f_fe     [64];
   int          left;
   logic [29:0] baddr, cap_addr;
   int          cap_len;

   function automatic logic [31:0] pat(int i);
      return {8'(i), 8'hC3, 8'(255 - i), 8'(i * 7)};
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic put_desc(input int w, input bit fe, input bit hold, input bit hi,
                           input int no, input int nxt, input int bufp);
      mem[w]   = {fe, hold, hi, 16'h0, 13'(no)};
      mem[w+1] = 32'(nxt);
      mem[w+2] = 32'(bufp);
   endtask

   // memory model and output monitor
   always @(negedge clk) begin
      if (!rst_n) begin
         rd_gnt = 0; rd_vld = 0; left = 0;
         nreq = 0; nwr = 0; nfi = 0; nhi = 0; fi_wr = -1; hi_wr = -1;
      end else begin
         if (fifo_wr) begin
            if (nwr < 64) begin
               f_data[nwr] = fifo_data; f_be[nwr] = fifo_be; f_fe[nwr] = fifo_fe;
            end
            nwr++;
         end
         if (irq_fi) begin nfi++; fi_wr = nwr; end
         if (irq_hi) begin nhi++; hi_wr = nwr; end
         rd_vld = 0;
         if (left > 0) begin
            rd_vld = 1; rd_data = mem[baddr[7:0]]; baddr++; left--;
         end else if (rd_gnt) begin
            rd_gnt = 0; left = cap_len; baddr = cap_addr;
         end else if (rd_req) begin
            rd_gnt = 1; cap_addr = rd_addr; cap_len = int'(rd_len);
            if (nreq < 16) begin req_addr[nreq] = rd_addr; req_len[nreq] = int'(rd_len); end
            nreq++;
         end
      end
   end

   task automatic do_reset();
      rst_n = 0; lda_mode = 0; fifo_space = 6'd31; poll = 0;
      for (int i = 0; i < 256; i++) mem[i] = pat(i);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic do_poll();
      @(negedge clk); poll = 1;
      @(negedge clk); poll = 0;
   endtask

   task automatic t_reset();
      rst_n = 0;
      repeat (3) @(negedge clk);
      chk(!rd_req && !fifo_wr && !irq_fi && !irq_hi, "R1 reset outputs quiet",
          {rd_req, fifo_wr, irq_fi, irq_hi}, 0);
   endtask

   task automatic t_hold_chain();
      do_reset();
      put_desc(0, 1, 1, 0, 9, 32'h30, 32'h102);
      desc_base = 0;
      do_poll();
      repeat (40) @(negedge clk);
      chk(req_addr[0] == 0 && req_len[0] == 3, "R1 descriptor fetch", req_len[0], 3);
      chk(req_addr[1] == 30'h40 && req_len[1] == 3, "R3 buffer request", int'(req_addr[1]), 'h40);
      chk(nwr == 3, "R3 word count", nwr, 3);
      chk(f_data[0] == mem[8'h40] && f_data[2] == mem[8'h42], "R6 data passthrough",
          f_data[2], mem[8'h42]);
      chk(f_be[0] == 4'b1100, "R6 first lanes", f_be[0], 4'b1100);
      chk(f_be[1] == 4'b1111, "R6 middle lanes", f_be[1], 4'b1111);
      chk(f_be[2] == 4'b0111, "R6 last lanes", f_be[2], 4'b0111);
      chk(!f_fe[0] && !f_fe[1] && f_fe[2], "R7 frame end on last", {f_fe[0], f_fe[1], f_fe[2]}, 1);
      chk(nfi == 1 && fi_wr == 3, "R8 frame interrupt after data", fi_wr, 3);
      chk(nhi == 0, "R9 no host interrupt", nhi, 0);
      chk(nreq == 2, "R10 parked on hold (R2 hold bit)", nreq, 2);
      // poll with hold still set
      do_poll();
      repeat (20) @(negedge clk);
      chk(nreq == 3 && req_addr[2] == 0 && req_len[2] == 2, "R10 re-read then park", nreq, 3);
      chk(nwr == 3, "R10 no data on re-read", nwr, 3);
      // clear hold, point on
      put_desc(0, 1, 0, 0, 9, 32'h30, 32'h102);
      put_desc(12, 0, 1, 1, 160, 0, 32'h200);
      do_poll();
      repeat (150) @(negedge clk);
      chk(req_addr[3] == 0 && req_len[3] == 2, "R10 second re-read", req_len[3], 2);
      chk(req_addr[4] == 30'h0C && req_len[4] == 3, "R10 branch to re-read pointer",
          int'(req_addr[4]), 'h0C);
      chk(req_addr[5] == 30'h80 && req_len[5] == 15, "R4 burst one", req_len[5], 15);
      chk(req_addr[6] == 30'h8F && req_len[6] == 15, "R4 burst two", int'(req_addr[6]), 'h8F);
      chk(req_addr[7] == 30'h9E && req_len[7] == 10, "R4 burst three", req_len[7], 10);
      chk(nreq == 8, "R4 request total", nreq, 8);
      chk(nwr == 43 && f_data[42] == mem[8'hA7], "R3 long buffer words", nwr, 43);
      chk(f_be[3] == 4'hF && f_be[42] == 4'hF, "R6 aligned lanes", f_be[42], 4'hF);
      chk(!f_fe[42], "R7 no frame end when flag clear", f_fe[42], 0);
      chk(nhi == 1 && hi_wr == 43, "R9 host interrupt after all data", hi_wr, 43);
      chk(nfi == 1, "R8 no frame interrupt when flag clear", nfi, 1);
   endtask

   task automatic t_edges();
      do_reset();
      put_desc(8, 0, 0, 0, 1, 32'h30, 32'h103);
      put_desc(12, 1, 1, 1, 0, 0, 32'h300);
      desc_base = 32'h20;
      do_poll();
      repeat (50) @(negedge clk);
      chk(req_addr[0] == 30'h08 && req_len[2] == 3 && req_addr[2] == 30'h0C,
          "R12 automatic branch", int'(req_addr[2]), 'h0C);
      chk(req_addr[1] == 30'h40 && req_len[1] == 1, "R3 single word buffer", req_len[1], 1);
      chk(nreq == 3, "R3 zero count reads nothing", nreq, 3);
      chk(nwr == 1 && f_be[0] == 4'b1000, "R6 combined lanes", f_be[0], 4'b1000);
      chk(!f_fe[0], "R7 flag clear on first descriptor", f_fe[0], 0);
      chk(nfi == 1 && nhi == 1, "R8 interrupts on empty descriptor", nfi + nhi, 2);
   endtask

   task automatic t_space();
      do_reset();
      fifo_space = 6'd5;
      put_desc(0, 1, 1, 0, 32, 0, 32'h100);
      desc_base = 0;
      do_poll();
      repeat (30) @(negedge clk);
      chk(nreq == 1 && !rd_req, "R5 burst withheld", nreq, 1);
      chk(nwr == 0, "R5 no data while short", nwr, 0);
      fifo_space = 6'd8;
      repeat (30) @(negedge clk);
      chk(nreq == 2 && req_len[1] == 8, "R5 burst at exact space", req_len[1], 8);
      chk(nwr == 8, "R5 data after space", nwr, 8);
   endtask

   task automatic t_lda();
      do_reset();
      lda_mode = 1;
      last_addr = 32'h0C;
      put_desc(0, 0, 1, 0, 4, 32'h0C, 32'h100);
      put_desc(3, 0, 0, 0, 4, 32'h18, 32'h104);
      put_desc(6, 1, 0, 0, 4, 32'h24, 32'h108);
      desc_base = 0;
      do_poll();
      repeat (60) @(negedge clk);
      chk(nreq == 4 && req_addr[2] == 30'h03, "R11 hold ignored, stop at last", nreq, 4);
      chk(nwr == 2, "R11 two buffers moved", nwr, 2);
      do_poll();
      repeat (20) @(negedge clk);
      chk(nreq == 4, "R11 unchanged last address ignored", nreq, 4);
      last_addr = 32'h18;
      do_poll();
      repeat (40) @(negedge clk);
      chk(nreq == 6 && req_addr[4] == 30'h06 && req_addr[5] == 30'h42,
          "R11 resume after move", nreq, 6);
      chk(nfi == 1, "R11 third descriptor completed", nfi, 1);
   endtask

   initial begin
      t_reset();
      t_hold_chain();
      t_edges();
      t_space();
      t_lda();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      #(20000 * 8);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

endmodule